// File: doc/BRIEF.md
# CPU Reset Sampling Controller

This block handles the active-low reset pin of an 8-bit processor core whose bus runs in machine cycles, each made of clock states (T-states). The rest of the core reports where it is through four strobes: the current machine cycle is an opcode fetch, and the current clock state is the first state, the second state, or the last state of its cycle. On each rising clock edge the block looks at the reset pin at these positions and picks one of two reactions. A full reset clears the architectural state and runs a recovery sequence. A partial reset clears only the program counter and keeps all other registers.

A full reset is taken when the pin is low in the last state of any machine cycle. From then on the block holds the fetch sequencer idle. After the pin is released it waits a set number of recovery cycles, then gives one cycle with a spurious read strobe pulse. Next comes the first clock state of a new fetch at address 0. In that state the memory-request and read strobes are flagged as indeterminate. Outside simulation X values are not reliable, so each indeterminate strobe has its own flag bit. A partial reset is taken when the pin is low in the second state of an opcode fetch. It raises its own latch and a one-cycle program-counter clear. The latch falls at the next fetch start once the pin is high. If the pin is still low at a last state, the partial reset becomes a full reset.

The block also keeps the internal halt latch. A HALT instruction sets it. An interrupt acknowledge, a non-maskable interrupt acknowledge or either kind of reset clears it.

The controller has seven states:
- `ST_RUN`: normal operation.
- `ST_SRES_CLR` and `ST_SRES_WAIT`: the two states of the partial reset.
- `ST_NRES_HOLD`, `ST_NRES_RECOVER`, `ST_NRES_GLITCH` and `ST_NRES_FIRST_T1`: the steps of the full reset.

Its transitions are:
- run→hold on a full-reset sample.
- run→sres_clr on a partial-reset sample.
- sres_clr/sres_wait→hold on escalation.
- sres_clr/sres_wait→run when a fetch opens with the pin high.
- sres_clr→sres_wait otherwise.
- hold→recover on release.
- recover→glitch when the counter expires.
- glitch→first_t1, then first_t1→run.
- any full-reset state→hold when the pin is low.

Top module: `rstseq_ctrl`

## Requirements
- R1: With the pin low in the last clock state of any machine cycle (t_last=1) while running, the next cycle shows nres_latch=1, arch_clear=1, pc_clear=1 and seq_hold=1, and these stay asserted while the pin stays low.
- R2: While running, a low pin at any clock state that is neither a last state nor the second state of a fetch has no effect: all outputs stay at their running values, and halt_latch keeps its value.
- R3: With the pin low when cyc_fetch=1 and t_second=1 while running, the next cycle shows sres_latch=1 and pc_clear=1 with arch_clear=0 and seq_hold=0; the cycle after that shows pc_clear=0 while sres_latch stays 1.
- R4: The special latch clears in the cycle after a sample with cyc_fetch=1, t_first=1 and the pin high.
- R5: While the special latch is set, a low pin with t_last=1 escalates to a full reset: the next cycle shows nres_latch=1 and sres_latch=0.
- R6: After the pin is sampled high during hold, seq_hold stays 1 for RECOVER_CYCLES+1 cycles, and nres_latch stays 1 throughout.
- R7: In the final held cycle, rd_spurious=1 (the spurious read low pulse) for exactly one cycle.
- R8: The cycle after the spurious pulse shows seq_start=1, mreq_indet=1, rd_indet=1 and nres_latch=0, all for one cycle only; after that every reset output is 0.
- R9: A low pin at any cycle of recovery returns the block to hold. While in hold, a fetch second-state sample does not set the special latch.
- R10: A HALT sets halt_latch in the next cycle. irq_ack, nmi_ack or entry to either reset clears it, and a clear wins over a set in the same cycle.
- R11: nres_latch and sres_latch are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; everything is sampled on its rising edge |
| reset_pin_n | input | 1 | Active-low reset pin, synchronous |
| cyc_fetch | input | 1 | Current machine cycle is an opcode fetch |
| t_first | input | 1 | First clock state of the current cycle |
| t_second | input | 1 | Second clock state of the current cycle |
| t_last | input | 1 | Last clock state of the current cycle |
| halt_exec | input | 1 | A HALT instruction sets the halt latch |
| irq_ack | input | 1 | Maskable interrupt acknowledged |
| nmi_ack | input | 1 | Non-maskable interrupt acknowledged |
| nres_latch | output | 1 | Full-reset latch |
| sres_latch | output | 1 | Partial-reset latch |
| pc_clear | output | 1 | Clear the program counter to 0 |
| arch_clear | output | 1 | Clear interrupt enables and interrupt mode, load I and R with 0 |
| seq_hold | output | 1 | Hold the fetch sequencer idle |
| seq_start | output | 1 | Start a fresh fetch at address 0 |
| mreq_indet | output | 1 | Memory-request strobe is indeterminate this cycle |
| rd_indet | output | 1 | Read strobe is indeterminate this cycle |
| rd_spurious | output | 1 | Read strobe driven low for the spurious pulse |
| halt_latch | output | 1 | Internal halt state |

## Verification
The bench builds the block with RECOVER_CYCLES set to 2, below the default of 3. This keeps every recovery cycle inside a short table. It also means that a counter that loads one value too many or too few shows up as a shifted spurious pulse. The hold length check after release then measures the window directly: RECOVER_CYCLES+1 cycles with the sequencer held.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_RUN           = 3'd0,
        ST_SRES_CLR      = 3'd1,
        ST_SRES_WAIT     = 3'd2,
        ST_NRES_HOLD     = 3'd3,
        ST_NRES_RECOVER  = 3'd4,
        ST_NRES_GLITCH   = 3'd5,
        ST_NRES_FIRST_T1 = 3'd6
    } rst_state_e;

    typedef struct packed {
        logic nres;
        logic sres;
        logic pc_clr;
        logic arch_clr;
        logic hold;
        logic start;
        logic mreq_x;
        logic rd_x;
        logic rd_spur;
    } rst_out_s;

endpackage

// File: rtl/rstseq_sampler.sv
module rstseq_sampler (
    input  logic pin_n,
    input  logic fetch,
    input  logic t1,
    input  logic t2,
    input  logic tlast,
    output logic pin_low,
    output logic norm_hit,
    output logic spec_hit,
    output logic fetch_open
);
    always_comb begin
        pin_low    = ~pin_n;
        // a last-state sample takes priority over the fetch second state
        norm_hit   = ~pin_n & tlast;
        spec_hit   = ~pin_n & fetch & t2 & ~tlast;
        fetch_open = pin_n & fetch & t1;
    end
endmodule

// File: rtl/rstseq_recov_cnt.sv
module rstseq_recov_cnt #(
    parameter int W        = 2,
    parameter int LOAD_VAL = 2
) (
    input  logic clk,
    input  logic load,
    input  logic step,
    output logic done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (load)
            cnt_q <= W'(LOAD_VAL);
        else if (step && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/rstseq_halt.sv
module rstseq_halt (
    input  logic clk,
    input  logic set_req,
    input  logic clr_req,
    output logic halt_q
);
    always_ff @(posedge clk) begin
        if (clr_req)
            halt_q <= 1'b0;
        else if (set_req)
            halt_q <= 1'b1;
    end
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int RECOVER_CYCLES = 3
) (
    input  logic clk,
    input  logic reset_pin_n,
    input  logic cyc_fetch,
    input  logic t_first,
    input  logic t_second,
    input  logic t_last,
    input  logic halt_exec,
    input  logic irq_ack,
    input  logic nmi_ack,
    output logic nres_latch,
    output logic sres_latch,
    output logic pc_clear,
    output logic arch_clear,
    output logic seq_hold,
    output logic seq_start,
    output logic mreq_indet,
    output logic rd_indet,
    output logic rd_spurious,
    output logic halt_latch
);
    localparam int RC    = (RECOVER_CYCLES < 1) ? 1 : RECOVER_CYCLES;
    localparam int CNT_W = (RC > 1) ? $clog2(RC) : 1;
    localparam int LOADV = RC - 1;

    rst_state_e state_q, state_d;
    rst_out_s   outs;
    logic       pin_low, norm_hit, spec_hit, fetch_open;
    logic       cnt_done, halt_clr;

    rstseq_sampler u_sampler (
        .pin_n      (reset_pin_n),
        .fetch      (cyc_fetch),
        .t1         (t_first),
        .t2         (t_second),
        .tlast      (t_last),
        .pin_low    (pin_low),
        .norm_hit   (norm_hit),
        .spec_hit   (spec_hit),
        .fetch_open (fetch_open)
    );

    rstseq_recov_cnt #(
        .W        (CNT_W),
        .LOAD_VAL (LOADV)
    ) u_cnt (
        .clk  (clk),
        .load (state_q == ST_NRES_HOLD),
        .step (state_q == ST_NRES_RECOVER),
        .done (cnt_done)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (norm_hit)      state_d = ST_NRES_HOLD;
                else if (spec_hit) state_d = ST_SRES_CLR;
            end
            ST_SRES_CLR, ST_SRES_WAIT: begin
                if (norm_hit)        state_d = ST_NRES_HOLD;
                else if (fetch_open) state_d = ST_RUN;
                else                 state_d = ST_SRES_WAIT;
            end
            ST_NRES_HOLD: begin
                state_d = pin_low ? ST_NRES_HOLD : ST_NRES_RECOVER;
            end
            ST_NRES_RECOVER: begin
                if (pin_low)       state_d = ST_NRES_HOLD;
                else if (cnt_done) state_d = ST_NRES_GLITCH;
            end
            ST_NRES_GLITCH: begin
                state_d = pin_low ? ST_NRES_HOLD : ST_NRES_FIRST_T1;
            end
            ST_NRES_FIRST_T1: begin
                state_d = pin_low ? ST_NRES_HOLD : ST_RUN;
            end
            default: state_d = ST_NRES_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // output decode
    always_comb begin
        outs = '0;
        unique case (state_q)
            ST_RUN: ;
            ST_SRES_CLR: begin
                outs.sres   = 1'b1;
                outs.pc_clr = 1'b1;
            end
            ST_SRES_WAIT: outs.sres = 1'b1;
            ST_NRES_HOLD: begin
                outs.nres     = 1'b1;
                outs.pc_clr   = 1'b1;
                outs.arch_clr = 1'b1;
                outs.hold     = 1'b1;
            end
            ST_NRES_RECOVER: begin
                outs.nres = 1'b1;
                outs.hold = 1'b1;
            end
            ST_NRES_GLITCH: begin
                outs.nres    = 1'b1;
                outs.hold    = 1'b1;
                outs.rd_spur = 1'b1;
            end
            ST_NRES_FIRST_T1: begin
                outs.start  = 1'b1;
                outs.mreq_x = 1'b1;
                outs.rd_x   = 1'b1;
            end
            default: outs = '0;
        endcase
    end

    assign halt_clr = irq_ack | nmi_ack |
                      (state_d == ST_NRES_HOLD) | (state_d == ST_SRES_CLR);

    rstseq_halt u_halt (
        .clk     (clk),
        .set_req (halt_exec),
        .clr_req (halt_clr),
        .halt_q  (halt_latch)
    );

    assign nres_latch  = outs.nres;
    assign sres_latch  = outs.sres;
    assign pc_clear    = outs.pc_clr;
    assign arch_clear  = outs.arch_clr;
    assign seq_hold    = outs.hold;
    assign seq_start   = outs.start;
    assign mreq_indet  = outs.mreq_x;
    assign rd_indet    = outs.rd_x;
    assign rd_spurious = outs.rd_spur;
endmodule

// File: rtl/rstseq_ctrl_chk.sv
module rstseq_ctrl_chk (
    input logic clk,
    input logic reset_pin_n,
    input logic cyc_fetch,
    input logic t_first,
    input logic t_second,
    input logic t_last,
    input logic halt_exec,
    input logic irq_ack,
    input logic nmi_ack,
    input logic nres_latch,
    input logic sres_latch,
    input logic pc_clear,
    input logic arch_clear,
    input logic seq_hold,
    input logic seq_start,
    input logic mreq_indet,
    input logic rd_indet,
    input logic rd_spurious,
    input logic halt_latch
);
    logic armed;

    always_ff @(posedge clk) begin
        armed <= (armed === 1'b1) | (nres_latch === 1'b1);
    end

    p_norm_entry_r1: assert property (@(posedge clk) disable iff (!armed)
        (!reset_pin_n && t_last && !nres_latch) |=> (nres_latch && arch_clear && seq_hold));

    p_ignore_r2: assert property (@(posedge clk) disable iff (!armed)
        (!reset_pin_n && !t_last && !(cyc_fetch && t_second) &&
         !nres_latch && !sres_latch && !seq_start) |=> (!nres_latch && !sres_latch));

    p_spec_entry_r3: assert property (@(posedge clk) disable iff (!armed)
        (!reset_pin_n && cyc_fetch && t_second && !t_last &&
         !nres_latch && !sres_latch && !seq_start)
        |=> (sres_latch && pc_clear && !arch_clear && !seq_hold));

    p_spec_exit_r4: assert property (@(posedge clk) disable iff (!armed)
        (sres_latch && reset_pin_n && cyc_fetch && t_first) |=> !sres_latch);

    p_escalate_r5: assert property (@(posedge clk) disable iff (!armed)
        (sres_latch && !reset_pin_n && t_last) |=> nres_latch);

    p_spur_held_r7: assert property (@(posedge clk) disable iff (!armed)
        rd_spurious |-> (seq_hold && nres_latch));

    p_first_fetch_r8: assert property (@(posedge clk) disable iff (!armed)
        (rd_spurious && reset_pin_n) |=> (seq_start && mreq_indet && rd_indet && !nres_latch));

    p_halt_clear_r10: assert property (@(posedge clk) disable iff (!armed)
        (irq_ack || nmi_ack) |=> !halt_latch);

    p_latch_excl_r11: assert property (@(posedge clk) disable iff (!armed)
        !(nres_latch && sres_latch));
endmodule

bind rstseq_ctrl rstseq_ctrl_chk u_rstseq_chk (.*);

// File: tb/test_rstseq_ctrl.sv
`timescale 1ns/100ps
module test_rstseq_ctrl;
    localparam int RCY = 2;

    logic clk = 1'b0;
    logic reset_pin_n, cyc_fetch, t_first, t_second, t_last;
    logic halt_exec, irq_ack, nmi_ack;
    logic nres_latch, sres_latch, pc_clear, arch_clear, seq_hold, seq_start;
    logic mreq_indet, rd_indet, rd_spurious, halt_latch;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rstseq_ctrl #(.RECOVER_CYCLES(RCY)) i_rstseq_ctrl (
        .clk(clk), .reset_pin_n(reset_pin_n), .cyc_fetch(cyc_fetch),
        .t_first(t_first), .t_second(t_second), .t_last(t_last),
        .halt_exec(halt_exec), .irq_ack(irq_ack), .nmi_ack(nmi_ack),
        .nres_latch(nres_latch), .sres_latch(sres_latch), .pc_clear(pc_clear),
        .arch_clear(arch_clear), .seq_hold(seq_hold), .seq_start(seq_start),
        .mreq_indet(mreq_indet), .rd_indet(rd_indet), .rd_spurious(rd_spurious),
        .halt_latch(halt_latch)
    );

    // {req[3:0], in: rst_n fetch t1 t2 tlast halt irq nmi,
    //  exp: nres sres pc arch hold start mreq_x rd_x spur halt}
    localparam logic [21:0] VECS [0:22] = '{
        22'b0001_00001000_1011100000, // R1 sample on last state
        22'b0001_00000000_1011100000, // R1 held
        22'b0110_10000000_1000100000, // R6 recover
        22'b0110_10000000_1000100000, // R6 recover
        22'b0111_10000000_1000100010, // R7 spurious read
        22'b1000_10000000_0000011100, // R8 fresh fetch, indeterminate
        22'b1000_11100000_0000000000, // R8 back to run
        22'b1010_10000100_0000000001, // R10 halt set
        22'b0010_01100000_0000000001, // R2 low at fetch T1 ignored
        22'b0010_00010000_0000000001, // R2 low at non-fetch T2 ignored
        22'b0011_01010000_0110000000, // R3 special sample
        22'b0011_11000000_0100000000, // R3 pc clear one cycle only
        22'b0100_11100000_0000000000, // R4 special cleared
        22'b1010_10000100_0000000001, // R10 set
        22'b1010_10000110_0000000000, // R10 clear wins over set
        22'b1010_10000100_0000000001, // R10 set
        22'b1010_10000001_0000000000, // R10 nmi clears
        22'b0011_01010000_0110000000, // R3 special again
        22'b0101_00001000_1011100000, // R5 escalate
        22'b1001_10000000_1000100000, // R9 recover
        22'b1001_00000000_1011100000, // R9 back to hold
        22'b1001_01010000_1011100000, // R9 no special during hold
        22'b1011_00000000_1011100000  // R11 latches exclusive
    };

    function automatic logic [9:0] outs_now();
        return {nres_latch, sres_latch, pc_clear, arch_clear, seq_hold,
                seq_start, mreq_indet, rd_indet, rd_spurious, halt_latch};
    endfunction

    task automatic drive(input logic [7:0] v);
        {reset_pin_n, cyc_fetch, t_first, t_second, t_last,
         halt_exec, irq_ack, nmi_ack} = v;
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int holds;
        drive(8'b0000_1000);
        foreach (VECS[k]) begin
            drive(VECS[k][17:10]);
            @(posedge clk); #1;
            check({22'd0, outs_now()}, {22'd0, VECS[k][9:0]},
                  $sformatf("R%0d row %0d", VECS[k][21:18], k));
            check({31'd0, nres_latch & sres_latch}, 32'd0, "R11");
        end

        // R6: hold window length after release
        holds = 0;
        drive(8'b1000_0000);
        for (int c = 0; c < 20 && !seq_start; c++) begin
            @(posedge clk); #1;
            if (seq_hold) holds++;
        end
        check(holds, RCY + 1, "R6 hold cycles");
        check({31'd0, mreq_indet & rd_indet}, 32'd1, "R8 indeterminate");
        @(posedge clk); #1;
        check({29'd0, mreq_indet, rd_indet, seq_start}, 32'd0, "R8 single cycle");

        // R1: full reset from a non-fetch last state
        drive(8'b0000_1000);
        @(posedge clk); #1;
        check({29'd0, nres_latch, arch_clear, pc_clear}, 32'd7, "R1 non-fetch last state");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule